// File: doc/BRIEF.md
# Power-Fail Debounce and Host Lockout Controller

This block sits between a host bus and the register file of a battery-backed timekeeping core. It watches an asynchronous, active-low power-fail input. It filters that input with a debounce timer driven by a 1 kHz tick, in both directions. A change is accepted only after it has held steady for a full window. Once failure is accepted, the block raises a registered power-fail status and locks the host out. While locked out, chip select, read, write and address are blocked from reaching the core, and the data bus output enable is held off.

An access that is already underway when failure is accepted may finish first. An access held far too long is cut off by a forced lockout. A separate standby input marks the moment the battery takes over. On its rising edge the block clears the stored time-save enable, which freezes the saved time. Unless the keep-interrupts-on-backup bit is set, it also clears every stored interrupt enable. The host loads these three settings through a simple write strobe.

Top module: `pwr_lockout_ctrl`

## Requirements
- R1: After reset, `pf_status`, `lockout`, `ts_en` and `irq_en` are all 0.
- R2: `pf_status` rises only after the synchronized `pfail_n` has been low without interruption for `DEB_TICKS` ticks (default 32, inside 30..63). Any high sample restarts the count, so shorter low pulses leave `pf_status` at 0.
- R3: After `pfail_n` returns high, `pf_status` stays 1 until the input has been high for `DEB_TICKS` ticks. It then clears.
- R4: `pfail_n` passes through a two-flop synchronizer. `pf_status` changes only on the clock edge that samples `tick_1ms` high.
- R5: When failure is accepted with no host access active, `lockout` rises on the next clock edge. An access is `host_cs_n`=0 together with `host_rd_n`=0 or `host_wr_n`=0.
- R6: When failure is accepted during an access, `lockout` stays 0 while the access lasts. It rises on the clock edge after the access ends.
- R7: An access held through `FORCE_TICKS` ticks (default 31) after failure is accepted forces `lockout` to 1, even though the access continues.
- R8: While `lockout` is 1, `core_cs_n`, `core_rd_n` and `core_wr_n` are 1, `core_addr` is 0 and `host_doe` is 0, whatever the host drives. `host_doe` is 1 only for an unlocked read access.
- R9: `lockout` is only held while `pf_status` is 1. It clears on the edge after `pf_status` clears.
- R10: A rising edge on `standby` clears `ts_en` on the next clock edge. An accepted power failure alone leaves `ts_en` unchanged.
- R11: On a rising edge of `standby` with the stored keep-on-backup bit at 0, all `IRQ_W` bits of `irq_en` clear. With that bit at 1, they keep their value. Standby entry takes priority over a `cfg_we` write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| pfail_n | input | 1 | Asynchronous power-fail input, low = failing |
| standby | input | 1 | High while the battery supplies the block |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_addr | input | AW | Host register address |
| core_dout | input | DW | Read data from the core |
| cfg_we | input | 1 | Load the three settings below |
| cfg_ts_en | input | 1 | Time-save enable value to load |
| cfg_irq_en | input | IRQ_W | Interrupt enable values to load |
| cfg_irq_on_backup | input | 1 | Keep-interrupts-on-backup value to load |
| core_cs_n | output | 1 | Gated chip select to the core |
| core_rd_n | output | 1 | Gated read strobe to the core |
| core_wr_n | output | 1 | Gated write strobe to the core |
| core_addr | output | AW | Gated address to the core |
| host_dout | output | DW | Read data toward the host pins |
| host_doe | output | 1 | Data bus output enable, 0 = high impedance |
| lockout | output | 1 | Registered lockout state |
| pf_status | output | 1 | Registered debounced power-fail status |
| ts_en | output | 1 | Stored time-save enable |
| irq_en | output | IRQ_W | Stored interrupt enables |

## Verification
A change on `pfail_n` reaches the counter after two clocks. `pf_status` then moves on the edge of the `DEB_TICKS`-th qualifying tick. `lockout` follows one clock after its condition holds, and the standby clears land one clock after the `standby` edge. The gated strobes, address and output enable are combinational from `lockout` and the host pins.

The bench drives every input on the falling edge, and each tick is one clock high followed by three low. It waits three falling edges after any change on `pfail_n` before it counts ticks. It samples each result two clocks after the deciding tick or edge. Debounce boundaries are probed one tick before and on the deciding tick. Random glitch lengths below the window must never move the status.

// File: rtl/pwr_lockout_ctrl.sv
module pwr_lockout_ctrl #(
  parameter int DEB_TICKS   = 32,
  parameter int FORCE_TICKS = 31,
  parameter int AW          = 5,
  parameter int DW          = 8,
  parameter int IRQ_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1ms,
  input  logic             pfail_n,
  input  logic             standby,
  input  logic             host_cs_n,
  input  logic             host_rd_n,
  input  logic             host_wr_n,
  input  logic [AW-1:0]    host_addr,
  input  logic [DW-1:0]    core_dout,
  input  logic             cfg_we,
  input  logic             cfg_ts_en,
  input  logic [IRQ_W-1:0] cfg_irq_en,
  input  logic             cfg_irq_on_backup,
  output logic             core_cs_n,
  output logic             core_rd_n,
  output logic             core_wr_n,
  output logic [AW-1:0]    core_addr,
  output logic [DW-1:0]    host_dout,
  output logic             host_doe,
  output logic             lockout,
  output logic             pf_status,
  output logic             ts_en,
  output logic [IRQ_W-1:0] irq_en
);
  localparam int MAXT = (DEB_TICKS > FORCE_TICKS) ? DEB_TICKS : FORCE_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] DEB_LAST   = CW'(DEB_TICKS - 1);
  localparam logic [CW-1:0] FORCE_LAST = CW'(FORCE_TICKS - 1);

  logic          pf_meta, pf_sync;
  logic [CW-1:0] deb_cnt, hold_cnt;
  logic          sb_q, irq_keep;

  wire access    = !host_cs_n && (!host_rd_n || !host_wr_n);
  wire differs   = (pf_sync == pf_status);
  wire sb_entry  = standby && !sb_q;
  wire hold_done = tick_1ms && (hold_cnt == FORCE_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pf_meta <= 1'b1;
      pf_sync <= 1'b1;
    end else begin
      pf_meta <= pfail_n;
      pf_sync <= pf_meta;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      deb_cnt   <= '0;
      pf_status <= 1'b0;
    end else if (!differs) begin
      deb_cnt <= '0;
    end else if (tick_1ms) begin
      if (deb_cnt == DEB_LAST) begin
        deb_cnt   <= '0;
        pf_status <= !pf_status;
      end else begin
        deb_cnt <= deb_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_cnt <= '0;
      lockout  <= 1'b0;
    end else if (!pf_status) begin
      hold_cnt <= '0;
      lockout  <= 1'b0;
    end else if (lockout || !access || hold_done) begin
      hold_cnt <= '0;
      lockout  <= 1'b1;
    end else if (tick_1ms) begin
      hold_cnt <= hold_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sb_q     <= 1'b0;
      ts_en    <= 1'b0;
      irq_en   <= '0;
      irq_keep <= 1'b0;
    end else begin
      sb_q <= standby;
      if (sb_entry) begin
        ts_en <= 1'b0;
        if (!irq_keep) irq_en <= '0;
      end else if (cfg_we) begin
        ts_en    <= cfg_ts_en;
        irq_en   <= cfg_irq_en;
        irq_keep <= cfg_irq_on_backup;
      end
    end

  assign core_cs_n = host_cs_n | lockout;
  assign core_rd_n = host_rd_n | lockout;
  assign core_wr_n = host_wr_n | lockout;
  assign core_addr = lockout ? '0 : host_addr;
  assign host_dout = core_dout;
  assign host_doe  = !lockout && !host_cs_n && !host_rd_n;
endmodule

module pwr_lockout_ctrl_chk #(
  parameter int IRQ_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_1ms,
  input logic             standby,
  input logic             keep_bit,
  input logic             core_cs_n,
  input logic             host_doe,
  input logic             lockout,
  input logic             pf_status,
  input logic             ts_en,
  input logic [IRQ_W-1:0] irq_en
);
  // R4
  status_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pf_status) |-> $past(tick_1ms));
  // R8
  lock_blocks_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> (core_cs_n && !host_doe));
  // R9
  lock_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_status |=> !lockout);
  // R10
  standby_ts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby) |=> !ts_en);
  // R11
  standby_irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(standby) && !keep_bit) |=> (irq_en == '0));
endmodule

bind pwr_lockout_ctrl pwr_lockout_ctrl_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .standby(standby),
  .keep_bit(irq_keep), .core_cs_n(core_cs_n), .host_doe(host_doe),
  .lockout(lockout), .pf_status(pf_status), .ts_en(ts_en), .irq_en(irq_en));

// File: tb/pwr_lockout_ctrl_tb.sv
module pwr_lockout_ctrl_tb;
  localparam int DEB = 32, FRC = 31, AW = 5, DW = 8, IW = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pfail_n = 1'b1, standby = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] cdout = 8'h5A;
  logic cfg_we = 1'b0, cfg_ts = 1'b0, cfg_keep = 1'b0;
  logic [IW-1:0] cfg_irq = '0;
  logic ccs_n, crd_n, cwr_n, doe, lock, pfs, ts;
  logic [AW-1:0] caddr;
  logic [DW-1:0] hdout;
  logic [IW-1:0] irq;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_lockout_ctrl #(.DEB_TICKS(DEB), .FORCE_TICKS(FRC), .AW(AW), .DW(DW), .IRQ_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .pfail_n(pfail_n), .standby(standby),
    .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n), .host_addr(addr),
    .core_dout(cdout), .cfg_we(cfg_we), .cfg_ts_en(cfg_ts), .cfg_irq_en(cfg_irq),
    .cfg_irq_on_backup(cfg_keep), .core_cs_n(ccs_n), .core_rd_n(crd_n),
    .core_wr_n(cwr_n), .core_addr(caddr), .host_dout(hdout), .host_doe(doe),
    .lockout(lock), .pf_status(pfs), .ts_en(ts), .irq_en(irq));

  function automatic bit doe_expect(bit l, bit c, bit r);
    return !l && !c && !r;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      cyc(2);
    end
  endtask

  task automatic set_pf(bit v);
    pfail_n = v;
    cyc(3);
  endtask

  task automatic cfg(bit t, logic [IW-1:0] q, bit k);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ts = t; cfg_irq = q; cfg_keep = k;
    @(negedge clk) cfg_we = 1'b0;
  endtask

  task automatic go_failed();
    set_pf(1'b0);
    ticks(DEB);
  endtask

  task automatic go_good();
    set_pf(1'b1);
    ticks(DEB);
    cyc(2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1
    chk("R1 pf_status", pfs, 0); chk("R1 lockout", lock, 0);
    chk("R1 ts_en", ts, 0);      chk("R1 irq_en", irq, 0);

    // R2 random short glitches, each restarting the count
    for (int i = 0; i < 12; i++) begin
      set_pf(1'b0);
      ticks(int'($urandom_range(1, DEB - 1)));
      set_pf(1'b1);
      ticks(int'($urandom_range(0, 2)));
      chk("R2 glitch ignored", pfs, 0);
    end

    // R2 boundary, with R10 and R5
    cfg(1'b1, 8'hFF, 1'b0);
    set_pf(1'b0);
    ticks(DEB - 1);
    chk("R2 one tick short", pfs, 0);
    ticks(1);
    chk("R2 declared", pfs, 1);
    chk("R5 lockout idle bus", lock, 1);
    chk("R10 pfail keeps ts_en", ts, 1);

    // R8 host blocked while locked
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = 5'h13;
    #1;
    chk("R8 core_cs_n", ccs_n, 1); chk("R8 core_rd_n", crd_n, 1);
    chk("R8 core_addr", caddr, 0);
    chk("R8 host_doe", doe, doe_expect(lock, cs_n, rd_n));
    rd_n = 1'b1; wr_n = 1'b0;
    #1;
    chk("R8 core_wr_n", cwr_n, 1);
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;

    // R3 release boundary and R9
    set_pf(1'b1);
    ticks(DEB - 1);
    chk("R3 still failed", pfs, 1);
    chk("R9 lock held", lock, 1);
    ticks(1);
    chk("R3 released", pfs, 0);
    chk("R9 lock released", lock, 0);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = 5'h07;
    #1;
    chk("R8 unlocked passes addr", caddr, 5'h07);
    chk("R8 unlocked doe", doe, 1);
    chk("R8 data path", hdout, 8'h5A);

    // R6 access in progress completes, with R4 status exactly on the tick
    set_pf(1'b0);
    ticks(DEB);
    chk("R6 declared during access", pfs, 1);
    chk("R6 lockout deferred", lock, 0);
    chk("R6 access passes", ccs_n, 0);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    chk("R6 lock after access ends", lock, 1);
    go_good();

    // R7 forced lockout on held access
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0;
    go_failed();
    ticks(FRC - 1);
    chk("R7 not yet forced", lock, 0);
    ticks(1);
    chk("R7 forced", lock, 1);
    chk("R7 held write blocked", cwr_n, 1);
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    go_good();
    chk("R9 clear after forced", lock, 0);

    // R4 synchronizer latency: a tick before the second flop settles does not count
    pfail_n = 1'b0;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    ticks(DEB - 1);
    chk("R4 early tick not counted", pfs, 0);
    ticks(1);
    chk("R4 counted after sync", pfs, 1);
    go_good();

    // R10, R11 standby entry without keep
    cfg(1'b1, 8'hA5, 1'b0);
    @(negedge clk) standby = 1'b1;
    cyc(2);
    chk("R10 ts_en cleared", ts, 0);
    chk("R11 irq cleared", irq, 0);
    @(negedge clk) standby = 1'b0;

    // R11 keep bit set
    cfg(1'b1, 8'h3C, 1'b1);
    @(negedge clk) standby = 1'b1;
    cyc(2);
    chk("R10 ts_en cleared keep", ts, 0);
    chk("R11 irq kept", irq, 8'h3C);
    @(negedge clk) standby = 1'b0;

    // R11 entry beats simultaneous write
    cfg(1'b1, 8'hFF, 1'b0);
    @(negedge clk);
    standby = 1'b1; cfg_we = 1'b1; cfg_ts = 1'b1; cfg_irq = 8'h0F; cfg_keep = 1'b0;
    @(negedge clk) cfg_we = 1'b0;
    cyc(1);
    chk("R11 entry priority irq", irq, 0);
    chk("R11 entry priority ts", ts, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule